// File: doc/BRIEF.md
# Software Interrupt Router with Per-Sender Source Tracking

This block keeps the state of sixteen software-generated interrupts for each of up to eight CPUs. For every (CPU, interrupt) pair it holds a bitmap with one bit per sending CPU. A pair counts as pending while any bit of its bitmap is set. A CPU raises an interrupt by writing a dispatch word. The word carries the interrupt number, a target list and a filter mode. The block works out the target set and records the writer as a sender in each target's bitmap.

Software can also reach the bitmaps of one selected CPU through two byte-addressed windows, each sixteen bytes long. In the set window, written bits are ORed into the bitmaps. In the clear window, written bits are removed. Reading either window returns the bitmaps, one byte per interrupt. The block outputs a pending vector for every CPU. It also gives each CPU a one-cycle queue pulse whenever that CPU receives new pending state, so a downstream arbiter knows to look again.

Top module: `swint_router`

## Requirements
- R1: After a synchronous active-low reset, every bitmap is zero, every bit of `pend_vec` is low and every bit of `queue_pulse` is low.
- R2: A dispatch write decodes three fields: the interrupt number from bits [3:0], the target list from bits [23:16] (bit 16+n selects CPU n) and the filter mode from bits [25:24]. With filter mode 0, writer bit w is set in bitmap (n, id) for each listed CPU n. From the next cycle, `pend_vec[n*16+id]` is high.
- R3: Filter mode 1 targets every CPU below `active_cpus` except the writer. The target list is ignored.
- R4: Filter mode 2 targets only the writer. The target list is ignored.
- R5: Filter mode 3 changes no bitmap and raises no queue pulse.
- R6: A CPU numbered at or above `active_cpus` is never targeted by a dispatch, whatever the target list says.
- R7: `disp_rdata` is always zero.
- R8: A clear-window write to CPU `win_cpu` removes the written bits from each addressed bitmap. A pair whose bitmap becomes zero drops its pending bit in the next cycle.
- R9: A set-window write ORs the written bits into each addressed bitmap. If at least one addressed bitmap is nonzero afterwards, the CPU's `queue_pulse` bit is high for the next cycle.
- R10: Window addressing has two sizes. With `win_word` low, the access covers interrupt `win_addr` and uses data bits [7:0]. With `win_word` high, `win_addr` is a multiple of 4, and byte lane k (bits [8k+7:8k]) covers interrupt `win_addr+k`. When `win_en` is high, `win_rdata` returns the current bitmaps in the same lanes, with the unused upper bytes zero.
- R11: If a window write and a dispatch hit the same pair in one cycle, the window write is applied first and the dispatch bit is ORed in afterwards. A cleared writer bit therefore stays set.
- R12: In the cycle after a dispatch, `queue_pulse` is high for each targeted CPU. The bit falls again in the following cycle unless a new event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_cpus | input | 4 | Number of CPUs in use (1..8) |
| disp_we | input | 1 | Dispatch word write strobe |
| disp_cpu | input | 3 | CPU issuing the dispatch write |
| disp_wdata | input | 32 | Dispatch word |
| disp_rdata | output | 32 | Read value of the dispatch register (always zero) |
| win_en | input | 1 | Window access valid |
| win_we | input | 1 | Window access is a write |
| win_clr | input | 1 | 1 selects the clear window, 0 the set window |
| win_word | input | 1 | 1 for a 4-byte access, 0 for a single byte |
| win_cpu | input | 3 | CPU whose bitmaps the window addresses |
| win_addr | input | 4 | Byte offset in the window, which is the interrupt number |
| win_wdata | input | 32 | Window write data, one bitmap per byte lane |
| win_rdata | output | 32 | Window read data, one bitmap per byte lane |
| pend_vec | output | 128 | Pending bits, bit cpu*16+id |
| queue_pulse | output | 8 | One-cycle per-CPU strobe on new pending state |

## Verification
The assertions take four things for granted about the inputs. The dispatch writer and the window CPU are both below `active_cpus`. `active_cpus` lies between 1 and 8. A word-sized window address is a multiple of four. If these do not hold, the self-target and window checks have nothing meaningful to relate. The stimulus draws the writer and window CPU modulo the active count and clears the low two address bits for word accesses. It also switches `active_cpus` only between idle cycles.

// File: rtl/swint_pkg.sv
// Shared constants and types for the software interrupt router.
// Assumes a 32-bit register data path and a 16-entry interrupt space.
package swint_pkg;
    localparam int SGI_COUNT = 16;
    localparam int ID_W      = 4;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int LIST_LSB  = 16;
    localparam int MODE_LSB  = 24;

    typedef enum logic [1:0] {
        FILT_LIST   = 2'd0,
        FILT_OTHERS = 2'd1,
        FILT_SELF   = 2'd2,
        FILT_RSVD   = 2'd3
    } filter_e;
endpackage

// File: rtl/swint_target_decode.sv
// Decodes a dispatch word into an interrupt number and a target CPU mask.
// Assumes NCPU <= 8 and that the writer index is below active_cpus.
module swint_target_decode
    import swint_pkg::*;
#(
    parameter int NCPU = 8,
    localparam int CW   = $clog2(NCPU),
    localparam int CNTW = $clog2(NCPU + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_we,
    input  logic [CW-1:0]     disp_cpu,
    input  logic [DATA_W-1:0] disp_wdata,
    input  logic [CNTW-1:0]   active_cpus,
    output logic [NCPU-1:0]   tgt_mask,
    output logic [ID_W-1:0]   sgi_id,
    output logic [NCPU-1:0]   self_bit
);
    logic [NCPU-1:0] act_mask;
    filter_e         mode;
    logic            unused_fields;

    // Build the mask of CPUs currently in use.
    for (genvar i = 0; i < NCPU; i++) begin : g_act
        assign act_mask[i] = CNTW'(i) < active_cpus;
    end

    assign mode          = filter_e'(disp_wdata[MODE_LSB +: 2]);
    assign sgi_id        = disp_wdata[ID_W-1:0];
    assign self_bit      = NCPU'(1) << disp_cpu;
    assign unused_fields = ^{disp_wdata[DATA_W-1:MODE_LSB+2], disp_wdata[LIST_LSB-1:ID_W]};

    // Select the target set according to the filter mode.
    always_comb begin
        tgt_mask = '0;
        if (disp_we) begin
            unique case (mode)
                FILT_LIST:   tgt_mask = disp_wdata[LIST_LSB +: NCPU] & act_mask;
                FILT_OTHERS: tgt_mask = act_mask & ~self_bit;
                FILT_SELF:   tgt_mask = self_bit & act_mask;
                default:     tgt_mask = '0;
            endcase
        end
    end

    AST_TARGET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_mask & ~act_mask) == '0);                                   // R6
endmodule

// File: rtl/swint_lane_decode.sv
// Maps a window access onto per-interrupt hit flags and bit patterns.
// Assumes word accesses use an address that is a multiple of four.
module swint_lane_decode
    import swint_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic                               win_word,
    input  logic [ID_W-1:0]                    win_addr,
    input  logic [DATA_W-1:0]                  win_wdata,
    output logic [SGI_COUNT-1:0]               lane_hit,
    output logic [SGI_COUNT-1:0][NCPU-1:0]     lane_bits
);
    // Per interrupt: does the access cover it, and which byte carries its bits.
    for (genvar j = 0; j < SGI_COUNT; j++) begin : g_lane
        localparam logic [ID_W-1:0] JID  = ID_W'(j);
        localparam int              LANE = j % LANES;
        assign lane_hit[j]  = win_word ? (win_addr[ID_W-1:2] == JID[ID_W-1:2])
                                       : (win_addr == JID);
        assign lane_bits[j] = win_word ? win_wdata[8*LANE +: NCPU]
                                       : win_wdata[NCPU-1:0];
    end
endmodule

// File: rtl/swint_source_bank.sv
// Holds the sender bitmaps of one CPU's sixteen software interrupts.
// Applies the window update first, then ORs in a dispatch hit.
module swint_source_bank
    import swint_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           win_hit,
    input  logic                           win_clr,
    input  logic [SGI_COUNT-1:0]           lane_hit,
    input  logic [SGI_COUNT-1:0][NCPU-1:0] lane_bits,
    input  logic                           disp_hit,
    input  logic [ID_W-1:0]                disp_id,
    input  logic [NCPU-1:0]                disp_src,
    output logic [SGI_COUNT-1:0][NCPU-1:0] src_map,
    output logic [SGI_COUNT-1:0]           pend,
    output logic                           strobe
);
    logic [SGI_COUNT-1:0][NCPU-1:0] map_q, map_d, disp_vec, set_vec;
    logic                           raise_d, strobe_q;

    // Spread the dispatch and set-window bits onto their interrupt slots.
    for (genvar j = 0; j < SGI_COUNT; j++) begin : g_vec
        assign disp_vec[j] = (disp_hit && disp_id == ID_W'(j)) ? disp_src : '0;
        assign set_vec[j]  = (win_hit && !win_clr && lane_hit[j]) ? lane_bits[j] : '0;
        assign pend[j]     = |map_q[j];
    end

    // Next bitmaps: window update first, dispatch ORed afterwards.
    always_comb begin
        raise_d = disp_hit;
        for (int j = 0; j < SGI_COUNT; j++) begin
            map_d[j] = map_q[j];
            if (win_hit && lane_hit[j]) begin
                map_d[j] = win_clr ? (map_d[j] & ~lane_bits[j]) : (map_d[j] | lane_bits[j]);
                if (!win_clr && map_d[j] != '0) raise_d = 1'b1;
            end
            map_d[j] = map_d[j] | disp_vec[j];
        end
    end

    // State and queue strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            map_q    <= map_d;
            strobe_q <= raise_d;
        end
    end

    assign src_map = map_q;
    assign strobe  = strobe_q;

    AST_DISPATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        disp_hit |=> ((map_q & $past(disp_vec)) == $past(disp_vec)));    // R11
    AST_STROBE_ON_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        disp_hit |=> strobe_q);                                          // R12
    AST_SET_WINDOW_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !win_clr) |=> ((map_q & $past(set_vec)) == $past(set_vec))); // R9
    AST_CLEAR_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && win_clr && !disp_hit) |=> ((map_q & ~$past(map_q)) == '0));  // R8
    AST_STROBE_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (|pend));                                           // R9
endmodule

// File: rtl/swint_router.sv
// Top of the software interrupt router: dispatch decode, window lanes,
// one source bank per CPU and the window read multiplexer.
// Assumes win_cpu and disp_cpu lie below active_cpus.
module swint_router
    import swint_pkg::*;
#(
    parameter int NCPU = 8,
    localparam int CW   = $clog2(NCPU),
    localparam int CNTW = $clog2(NCPU + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNTW-1:0]           active_cpus,
    input  logic                      disp_we,
    input  logic [CW-1:0]             disp_cpu,
    input  logic [DATA_W-1:0]         disp_wdata,
    output logic [DATA_W-1:0]         disp_rdata,
    input  logic                      win_en,
    input  logic                      win_we,
    input  logic                      win_clr,
    input  logic                      win_word,
    input  logic [CW-1:0]             win_cpu,
    input  logic [ID_W-1:0]           win_addr,
    input  logic [DATA_W-1:0]         win_wdata,
    output logic [DATA_W-1:0]         win_rdata,
    output logic [NCPU*SGI_COUNT-1:0] pend_vec,
    output logic [NCPU-1:0]           queue_pulse
);
    logic [NCPU-1:0]                tgt_mask, self_bit;
    logic [ID_W-1:0]                sgi_id;
    logic [SGI_COUNT-1:0]           lane_hit;
    logic [SGI_COUNT-1:0][NCPU-1:0] lane_bits;
    logic [SGI_COUNT-1:0][NCPU-1:0] maps [NCPU];
    logic [SGI_COUNT-1:0][NCPU-1:0] sel_map;

    swint_target_decode #(.NCPU(NCPU)) u_decode (
        .clk(clk), .rst_n(rst_n), .disp_we(disp_we), .disp_cpu(disp_cpu),
        .disp_wdata(disp_wdata), .active_cpus(active_cpus),
        .tgt_mask(tgt_mask), .sgi_id(sgi_id), .self_bit(self_bit)
    );

    swint_lane_decode #(.NCPU(NCPU)) u_lanes (
        .win_word(win_word), .win_addr(win_addr), .win_wdata(win_wdata),
        .lane_hit(lane_hit), .lane_bits(lane_bits)
    );

    // One bitmap bank per CPU.
    for (genvar c = 0; c < NCPU; c++) begin : g_bank
        swint_source_bank #(.NCPU(NCPU)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .win_hit(win_en && win_we && win_cpu == CW'(c)),
            .win_clr(win_clr), .lane_hit(lane_hit), .lane_bits(lane_bits),
            .disp_hit(tgt_mask[c]), .disp_id(sgi_id), .disp_src(self_bit),
            .src_map(maps[c]), .pend(pend_vec[c*SGI_COUNT +: SGI_COUNT]),
            .strobe(queue_pulse[c])
        );
    end

    assign sel_map    = maps[win_cpu];
    assign disp_rdata = '0;

    // Return the addressed bitmaps, one per byte lane.
    always_comb begin
        win_rdata = '0;
        if (win_en) begin
            if (win_word) begin
                for (int k = 0; k < LANES; k++)
                    win_rdata[8*k +: 8] = 8'(sel_map[{win_addr[ID_W-1:2], 2'(k)}]);
            end else begin
                win_rdata[7:0] = 8'(sel_map[win_addr]);
            end
        end
    end

    AST_RESERVED_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_we && disp_wdata[MODE_LSB +: 2] == 2'b11 && !(win_en && win_we))
        |=> ($stable(pend_vec) && queue_pulse == '0));                   // R5
endmodule

// File: tb/swint_router_test.sv
`timescale 1ns/1ps
module swint_router_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  active_cpus = 4'd8;
    logic        disp_we = 0;
    logic [2:0]  disp_cpu = 0;
    logic [31:0] disp_wdata = 0;
    logic [31:0] disp_rdata;
    logic        win_en = 0, win_we = 0, win_clr = 0, win_word = 0;
    logic [2:0]  win_cpu = 0;
    logic [3:0]  win_addr = 0;
    logic [31:0] win_wdata = 0;
    logic [31:0] win_rdata;
    logic [127:0] pend_vec;
    logic [7:0]  queue_pulse;

    int checks = 0;
    int fails  = 0;
    int unsigned src [N][16];
    logic [7:0]  exp_q;

    always #2 clk = ~clk;

    swint_router uut (
        .clk(clk), .rst_n(rst_n), .active_cpus(active_cpus),
        .disp_we(disp_we), .disp_cpu(disp_cpu), .disp_wdata(disp_wdata),
        .disp_rdata(disp_rdata), .win_en(win_en), .win_we(win_we),
        .win_clr(win_clr), .win_word(win_word), .win_cpu(win_cpu),
        .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .pend_vec(pend_vec), .queue_pulse(queue_pulse)
    );

    task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read();
        logic [31:0] r = 0;
        if (win_word)
            for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'(src[win_cpu][{win_addr[3:2], 2'(k)}]);
        else
            r[7:0] = 8'(src[win_cpu][win_addr]);
        return r;
    endfunction

    function automatic logic [127:0] model_pend();
        logic [127:0] p = 0;
        for (int c = 0; c < N; c++)
            for (int j = 0; j < 16; j++) p[c*16+j] = (src[c][j] != 0);
        return p;
    endfunction

    // Behavioural update of the reference state at a clock edge.
    task automatic model_step();
        int unsigned tg;
        int unsigned am;
        int id;
        exp_q = 0;
        if (win_en && win_we) begin
            for (int k = 0; k < (win_word ? 4 : 1); k++) begin
                int j = win_word ? ({28'd0, win_addr} & 12) + k : int'(win_addr);
                int unsigned b = (win_wdata >> (8*k)) & 8'hFF;
                if (win_clr) src[win_cpu][j] &= ~b;
                else begin
                    src[win_cpu][j] |= b;
                    if (src[win_cpu][j] != 0) exp_q[win_cpu] = 1'b1;
                end
            end
        end
        if (disp_we) begin
            am = (1 << active_cpus) - 1;
            id = int'(disp_wdata[3:0]);
            case (disp_wdata[25:24])
                2'd0: tg = disp_wdata[23:16] & am;
                2'd1: tg = am & ~(1 << disp_cpu);
                2'd2: tg = (1 << disp_cpu) & am;
                default: tg = 0;
            endcase
            for (int c = 0; c < N; c++)
                if (tg[c]) begin
                    src[c][id] |= (1 << disp_cpu);
                    exp_q[c] = 1'b1;
                end
        end
    endtask

    task automatic idle();
        disp_we = 0; disp_wdata = 0; win_en = 0; win_we = 0;
        win_clr = 0; win_word = 0; win_wdata = 0;
    endtask

    // Inputs are set at a falling edge; check reads, clock, check state.
    task automatic do_cycle(string tag);
        #1;
        if (win_en) check(tag, "win_rdata", 128'(win_rdata), 128'(model_read()));
        check("R7", "disp_rdata", 128'(disp_rdata), 128'd0);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, "pend_vec", pend_vec, model_pend());
        check(tag, "queue_pulse", 128'(queue_pulse), 128'(exp_q));
        idle();
    endtask

    task automatic dispatch(input int w, input int mode, input int list, input int id, string tag);
        disp_we = 1; disp_cpu = 3'(w);
        disp_wdata = (32'(mode) << 24) | (32'(list) << 16) | 32'(id);
        do_cycle(tag);
    endtask

    task automatic window(input bit we, input bit clr, input bit word, input int cpu,
                          input int addr, input logic [31:0] data, string tag);
        win_en = 1; win_we = we; win_clr = clr; win_word = word;
        win_cpu = 3'(cpu); win_addr = 4'(addr); win_wdata = data;
        do_cycle(tag);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) for (int j = 0; j < 16; j++) src[c][j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1", "pend_vec after reset", pend_vec, 128'd0);
        check("R1", "queue_pulse after reset", 128'(queue_pulse), 128'd0);

        dispatch(1, 0, 8'h0A, 3, "R2");
        do_cycle("R12");
        dispatch(2, 1, 8'h00, 7, "R3");
        dispatch(5, 2, 8'hFF, 15, "R4");
        dispatch(0, 3, 8'hFF, 9, "R5");
        window(0, 0, 0, 3, 3, 0, "R10");
        window(0, 1, 1, 3, 4, 0, "R10");
        window(1, 0, 1, 4, 8, 32'h0081_0003, "R9");
        window(0, 0, 1, 4, 8, 0, "R10");
        window(1, 0, 0, 6, 2, 32'h0000_0000, "R9");
        window(1, 1, 0, 4, 8, 32'h0000_0001, "R8");
        window(1, 1, 0, 4, 8, 32'h0000_0002, "R8");
        window(1, 1, 1, 4, 8, 32'hFFFF_FFFF, "R8");
        disp_we = 1; disp_cpu = 3'd6; disp_wdata = (32'd0 << 24) | (32'h08 << 16) | 32'd3;
        win_en = 1; win_we = 1; win_clr = 1; win_cpu = 3'd3; win_addr = 4'd3; win_wdata = 32'hFF;
        do_cycle("R11");
        window(0, 0, 0, 3, 3, 0, "R11");

        active_cpus = 4'd5;
        dispatch(0, 0, 8'hFF, 12, "R6");
        dispatch(4, 1, 8'h00, 13, "R6");
        window(0, 0, 1, 7, 12, 0, "R6");

        for (int n = 0; n < 600; n++) begin
            int act;
            if (n == 300) active_cpus = 4'd8;
            act = int'(active_cpus);
            disp_we = 1'($urandom_range(0, 1));
            disp_cpu = 3'($urandom_range(0, act - 1));
            disp_wdata = $urandom;
            win_en = 1'($urandom_range(0, 1));
            win_we = 1'($urandom_range(0, 1));
            win_clr = 1'($urandom_range(0, 1));
            win_word = 1'($urandom_range(0, 1));
            win_cpu = 3'($urandom_range(0, act - 1));
            win_addr = 4'($urandom_range(0, 15));
            if (win_word) win_addr[1:0] = 2'b00;
            win_wdata = $urandom & $urandom;
            do_cycle("R11");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule